// File: doc/BRIEF.md
# Reservation Tracker for Atomic Load/Store Pairs

This block keeps the one reservation that a 64-bit core uses to build atomic read-modify-write sequences. A reserving load records that a reservation is held, the effective address and the access width. A later conditional store is judged against that record. If it passes, the block raises the memory write enable. In every case it returns a 4-bit condition code to the register-update path.

The block sees only the request strobes, the effective address, a 2-bit width code, the current summary-overflow bit and an external kill input, for example a snoop hit on the reserved line. The register file, the memory port and address generation lie outside it. Results are registered: each conditional store gets a one-cycle done pulse in the following cycle, together with the pass flag, the condition code and the write enable.

Top module: `lrsc_track`

## Requirements
- R1: A reserving load (`lr_req`) records a held reservation with its address `ea` and width code `acc_size`. A following conditional store with the same address and width passes.
- R2: A conditional store issued while no reservation is held fails.
- R3: Width codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. A conditional store passes only if its width code equals the recorded code exactly.
- R4: A conditional store passes only if all `ADDR_W` bits of its address equal the recorded address.
- R5: `sc_cond` is {2'b00, pass, so}. Bit 1 is 1 on success and 0 on failure, and bit 0 copies `so_in` as sampled with the request. It is 0 when no done pulse is present.
- R6: Every conditional store, whether it passes or fails, removes the reservation, so a second store with no new reserving load fails.
- R7: `wr_en` is high only together with a done pulse whose store passed.
- R8: A `kill` pulse removes the reservation in the cycle it is seen. A store in that same cycle fails. A reserving load in that same cycle leaves no reservation.
- R9: A new reserving load replaces any reservation already held.
- R10: `sc_done` pulses high for exactly the one cycle after each cycle with `sc_req`, and is low otherwise.
- R11: Reset (`rst`, synchronous, active high) removes the reservation and drives all outputs low.
- R12: When `lr_req` and `sc_req` are high in the same cycle, the store is judged against the old reservation and the load's reservation is then installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lr_req | input | 1 | Reserving load request |
| sc_req | input | 1 | Conditional store request |
| ea | input | ADDR_W | Effective address of the request |
| acc_size | input | 2 | Width code: 0=1B, 1=2B, 2=4B, 3=8B |
| so_in | input | 1 | Current summary-overflow bit |
| kill | input | 1 | External reservation kill |
| sc_done | output | 1 | One-cycle result pulse |
| sc_pass | output | 1 | Store passed |
| sc_cond | output | 4 | Condition code {00, pass, so} |
| wr_en | output | 1 | Memory write enable for the store |

## Verification
The conflicts of interest arise when a conditional store shares its cycle with either a reserving load or a kill pulse. A reserving load can also share its cycle with a kill.

The stimulus table places these pairs in single rows, so each pair of strobes is sampled on the same clock edge. For each pair, the check covers the immediate result and a follow-up store. A store alongside a new load must pass against the old record, and the next store must then pass against the new one. A store alongside a kill must fail. A load alongside a kill must leave nothing that a later store could use.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    localparam int NUM_SIZES = 4;

    typedef struct packed {
        logic      valid;
        acc_size_e len;
    } resv_meta_t;

    typedef struct packed {
        logic       done;
        logic       pass;
        logic [3:0] cond;
        logic       we;
    } sc_result_t;

    function automatic logic [3:0] make_cond(input logic pass, input logic so);
        return {2'b00, pass, so};
    endfunction

endpackage

// File: rtl/lrsc_resv_store.sv
module lrsc_resv_store
    import lrsc_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lr_req,
    input  logic              sc_req,
    input  logic              kill,
    input  logic [ADDR_W-1:0] ea,
    input  acc_size_e         size,
    output resv_meta_t        meta,
    output logic [ADDR_W-1:0] addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            meta.valid <= 1'b0;
            meta.len   <= SZ_BYTE;
            addr       <= '0;
        end else if (kill) begin
            meta.valid <= 1'b0;
        end else if (lr_req) begin
            meta.valid <= 1'b1;
            meta.len   <= size;
            addr       <= ea;
        end else if (sc_req) begin
            meta.valid <= 1'b0;
        end
    end

endmodule

// File: rtl/lrsc_sc_judge.sv
module lrsc_sc_judge
    import lrsc_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  resv_meta_t        meta,
    input  logic [ADDR_W-1:0] resv_addr,
    input  logic [ADDR_W-1:0] ea,
    input  acc_size_e         size,
    input  logic              kill,
    output logic              hit
);

    logic [NUM_SIZES-1:0] len_hit;

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_len
        assign len_hit[k] = (meta.len == acc_size_e'(k)) && (size == acc_size_e'(k));
    end

    always_comb begin
        hit = meta.valid && (|len_hit) && (resv_addr == ea) && !kill;
    end

endmodule

// File: rtl/lrsc_result_reg.sv
module lrsc_result_reg
    import lrsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sc_req,
    input  logic       hit,
    input  logic       so,
    output sc_result_t res
);

    sc_result_t res_d;

    always_comb begin
        res_d      = '0;
        res_d.done = sc_req;
        res_d.pass = sc_req && hit;
        res_d.we   = sc_req && hit;
        res_d.cond = sc_req ? make_cond(hit, so) : 4'b0000;
    end

    always_ff @(posedge clk) begin
        if (rst) res <= '0;
        else     res <= res_d;
    end

endmodule

// File: rtl/lrsc_track.sv
module lrsc_track
    import lrsc_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lr_req,
    input  logic              sc_req,
    input  logic [ADDR_W-1:0] ea,
    input  logic [1:0]        acc_size,
    input  logic              so_in,
    input  logic              kill,
    output logic              sc_done,
    output logic              sc_pass,
    output logic [3:0]        sc_cond,
    output logic              wr_en
);

    resv_meta_t        meta;
    logic [ADDR_W-1:0] resv_addr;
    logic              hit;
    sc_result_t        res;
    acc_size_e         size;

    assign size = acc_size_e'(acc_size);

    lrsc_resv_store #(.ADDR_W(ADDR_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .lr_req (lr_req),
        .sc_req (sc_req),
        .kill   (kill),
        .ea     (ea),
        .size   (size),
        .meta   (meta),
        .addr   (resv_addr)
    );

    lrsc_sc_judge #(.ADDR_W(ADDR_W)) u_judge (
        .meta      (meta),
        .resv_addr (resv_addr),
        .ea        (ea),
        .size      (size),
        .kill      (kill),
        .hit       (hit)
    );

    lrsc_result_reg u_result (
        .clk    (clk),
        .rst    (rst),
        .sc_req (sc_req),
        .hit    (hit),
        .so     (so_in),
        .res    (res)
    );

    assign sc_done = res.done;
    assign sc_pass = res.pass;
    assign sc_cond = res.cond;
    assign wr_en   = res.we;

endmodule

// File: rtl/lrsc_track_chk.sv
module lrsc_track_chk (
    input logic       clk,
    input logic       rst,
    input logic       lr_req,
    input logic       sc_req,
    input logic       so_in,
    input logic       kill,
    input logic       sc_done,
    input logic       sc_pass,
    input logic [3:0] sc_cond,
    input logic       wr_en
);

    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        sc_req |=> sc_done);                                          // R10
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
        !sc_req |=> !sc_done);                                        // R10
    AST_WE_ONLY_PASS: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (sc_done && sc_pass));                              // R7
    AST_COND_SO: assert property (@(posedge clk) disable iff (rst)
        sc_req |=> (sc_cond[0] == $past(so_in)));                     // R5
    AST_COND_SHAPE: assert property (@(posedge clk) disable iff (rst)
        sc_done |-> (sc_cond[3:2] == 2'b00 && sc_cond[1] == sc_pass)); // R5
    AST_KILL_FAILS: assert property (@(posedge clk) disable iff (rst)
        (sc_req && kill) |=> !sc_pass);                               // R8
    AST_SC_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (sc_req && $past(sc_req) && !$past(lr_req)) |=> !sc_pass);    // R6
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!sc_done && !wr_en && sc_cond == 4'b0000));          // R11

endmodule

bind lrsc_track lrsc_track_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .lr_req  (lr_req),
    .sc_req  (sc_req),
    .so_in   (so_in),
    .kill    (kill),
    .sc_done (sc_done),
    .sc_pass (sc_pass),
    .sc_cond (sc_cond),
    .wr_en   (wr_en)
);

// File: tb/lrsc_track_tb.sv
module lrsc_track_tb;

    localparam int ADDR_W = 64;
    localparam logic [63:0] A  = 64'h0000_1000_0000_0040;
    localparam logic [63:0] B  = 64'h0000_2000_0000_0080;
    localparam logic [63:0] A2 = 64'h0000_1000_0000_0042;
    localparam logic [63:0] AH = 64'h8000_1000_0000_0040;

    typedef struct packed {
        logic        lr;
        logic        sc;
        logic        kl;
        logic        so;
        logic [1:0]  sz;
        logic [63:0] ad;
        logic        pass;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t VEC [NV] = '{
        '{0,1,0,0,2'd3,A ,0,4'd2 },  // R2 store with nothing held
        '{1,0,0,0,2'd3,A ,0,4'd10},  // R1 load; R10 no done
        '{0,1,0,0,2'd3,A ,1,4'd1 },  // R1 pass
        '{0,1,0,0,2'd3,A ,0,4'd6 },  // R6 second store fails
        '{1,0,0,0,2'd2,A ,0,4'd1 },  // R1
        '{0,1,0,1,2'd2,A ,1,4'd5 },  // R5 cond 0011
        '{1,0,0,0,2'd0,A ,0,4'd3 },  // R3
        '{0,1,0,0,2'd1,A ,0,4'd3 },  // R3 width mismatch
        '{0,1,0,0,2'd0,A ,0,4'd6 },  // R6 cleared by failed store
        '{1,0,0,0,2'd1,A ,0,4'd4 },  // R4
        '{0,1,0,0,2'd1,A2,0,4'd4 },  // R4 address mismatch
        '{1,0,0,0,2'd3,A ,0,4'd9 },  // R9
        '{1,0,0,0,2'd3,B ,0,4'd9 },  // R9 overwrite
        '{0,1,0,0,2'd3,A ,0,4'd9 },  // R9 old address fails
        '{1,0,0,0,2'd3,B ,0,4'd9 },  // R9
        '{0,1,0,1,2'd3,B ,1,4'd9 },  // R9 new address passes
        '{1,0,0,0,2'd2,A ,0,4'd8 },  // R8
        '{0,0,1,0,2'd2,A ,0,4'd8 },  // R8 kill alone
        '{0,1,0,0,2'd2,A ,0,4'd8 },  // R8 store after kill fails
        '{1,0,0,0,2'd2,A ,0,4'd8 },  // R8
        '{0,1,1,0,2'd2,A ,0,4'd8 },  // R8 kill with store
        '{1,0,1,0,2'd2,A ,0,4'd8 },  // R8 kill with load
        '{0,1,0,0,2'd2,A ,0,4'd8 },  // R8 nothing held
        '{1,0,0,0,2'd3,A ,0,4'd12},  // R12
        '{1,1,0,0,2'd3,A ,1,4'd12},  // R12 store judged on old
        '{0,1,0,0,2'd3,A ,1,4'd12},  // R12 new reservation used
        '{1,0,0,0,2'd0,A ,0,4'd3 },  // R3
        '{0,1,0,1,2'd0,A ,1,4'd3 },  // R3 byte pass
        '{0,1,0,1,2'd0,A ,0,4'd5 },  // R5 fail with so -> 0001
        '{1,0,0,0,2'd1,A ,0,4'd3 },  // R3
        '{0,1,0,0,2'd1,A ,1,4'd3 },  // R3 half pass
        '{1,0,0,0,2'd2,A ,0,4'd3 },  // R3
        '{0,1,0,0,2'd3,A ,0,4'd3 },  // R3 word vs dword
        '{1,0,0,0,2'd3,A ,0,4'd4 },  // R4
        '{0,1,0,0,2'd3,AH,0,4'd4 }   // R4 top bit differs
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              lr_req, sc_req, so_in, kill;
    logic [ADDR_W-1:0] ea;
    logic [1:0]        acc_size;
    logic              sc_done, sc_pass, wr_en;
    logic [3:0]        sc_cond;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    lrsc_track #(.ADDR_W(ADDR_W)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .lr_req   (lr_req),
        .sc_req   (sc_req),
        .ea       (ea),
        .acc_size (acc_size),
        .so_in    (so_in),
        .kill     (kill),
        .sc_done  (sc_done),
        .sc_pass  (sc_pass),
        .sc_cond  (sc_cond),
        .wr_en    (wr_en)
    );

    task automatic check(input int req, input logic d, input logic p,
                         input logic [3:0] c, input logic w);
        checks++;
        if ({sc_done, sc_pass, sc_cond, wr_en} !== {d, p, c, w}) begin
            fails++;
            $display("FAIL R%0d: got done=%b pass=%b cond=%b we=%b, expected done=%b pass=%b cond=%b we=%b",
                     req, sc_done, sc_pass, sc_cond, wr_en, d, p, c, w);
        end
    endtask

    task automatic drive(input logic l, input logic s, input logic k,
                         input logic o, input logic [1:0] z, input logic [63:0] a);
        lr_req = l; sc_req = s; kill = k; so_in = o; acc_size = z; ea = a;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        drive(0, 0, 0, 0, 2'd0, '0);
        repeat (3) @(negedge clk);
        check(11, 0, 0, 4'b0000, 0);        // R11 reset state
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].lr, VEC[i].sc, VEC[i].kl, VEC[i].so, VEC[i].sz, VEC[i].ad);
            @(negedge clk);
            check(int'(VEC[i].req), VEC[i].sc, VEC[i].sc && VEC[i].pass,
                  VEC[i].sc ? {2'b00, VEC[i].pass, VEC[i].so} : 4'b0000,
                  VEC[i].sc && VEC[i].pass);   // R7 R10
        end

        drive(0, 0, 0, 0, 2'd0, '0);
        @(negedge clk);
        check(10, 0, 0, 4'b0000, 0);        // R10 done lasts one cycle

        // R11: reset drops a held reservation
        drive(1, 0, 0, 0, 2'd3, A);
        @(negedge clk);
        drive(0, 0, 0, 0, 2'd3, A);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        drive(0, 1, 0, 0, 2'd3, A);
        @(negedge clk);
        check(11, 1, 0, 4'b0000, 0);        // R11 store after reset fails

        // R11: reset during a store suppresses the result
        drive(1, 0, 0, 0, 2'd3, A);
        @(negedge clk);
        drive(0, 1, 0, 1, 2'd3, A);
        rst = 1'b1;
        @(negedge clk);
        check(11, 0, 0, 4'b0000, 0);        // R11 outputs low in reset
        rst = 1'b0;
        drive(0, 0, 0, 0, 2'd0, '0);
        @(negedge clk);

        finish_run();
    end

endmodule